// File: doc/BRIEF.md
# Bit-Sliced Pseudo-Random Test Word Generator

This block produces one 16-bit pseudo-random test word per clock for a single transmit lane of a link test. Each output bit comes from its own small linear feedback shift register. There are sixteen independent 5-bit registers, and bit i of the word is the top bit of register i. Every register steps through the maximal-length polynomial x^5 + x^3 + 1, so the word stream has a period of 31 enabled clocks.

A synchronous reset seeds every register. The top bit of register i is loaded from bit i of a 16-bit seed, which defaults to 16'h1A47. The remaining four bits of every register are loaded with a fixed nonzero tail, which defaults to 4'b0001. The first word of every period is therefore the seed itself, and a receiver can use it as an alignment marker. The registers advance only while the step-enable input is high. While it is low, the state holds and the word-valid output is low. Each transmit lane instantiates its own copy.

Top module: `bitslice_prbs_gen`

## Requirements
- R1: In any cycle after a reset edge and before the first enabled edge, word_o equals 16'h1A47.
- R2: Bit i of word_o is the top bit of lane register i. Each lane's top-bit stream b[n] obeys b[n+5] = b[n+2] xor b[n] (polynomial x^5 + x^3 + 1), with initial bits b[0..4] = seed bit i, 0, 0, 0, 1. The second through fifth of these are the 4'b0001 tail, read from its most significant bit down.
- R3: A lane register advances exactly once at each rising clock edge where step_en is 1 and rst is 0.
- R4: At an edge where step_en is 0 and rst is 0, word_o holds its value. While step_en is 0, word_vld_o is 0.
- R5: word_vld_o is 1 exactly when step_en is 1 and rst is 0.
- R6: The word after n enabled steps equals the word after n+31 enabled steps. The word is 16'h1A47 whenever the number of enabled steps since reset is a multiple of 31.
- R7: The word stream has no period shorter than 31 enabled steps.
- R8: Reset is synchronous and has priority over step_en. Asserting rst mid-sequence with step_en high yields 16'h1A47 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| step_en | input | 1 | Advance all lane registers at this edge |
| word_o | output | 16 | Current test word, bit i from lane i's top bit |
| word_vld_o | output | 1 | High while the current word is being emitted |

## Verification
A long run with enable held high checks the word against a bench model built from the lane recurrence. It also shows that the stream repeats after 31 steps and after no shorter shift, which separates a correct polynomial and tap choice from a wrong one. Randomly gated enable patterns separate a design that steps on every clock from one that holds correctly. Resets dropped at random points, including with enable high, check the seeding and the priority of reset over enable.

// File: rtl/bitslice_prbs_gen.sv
module bitslice_prbs_gen #(
  parameter int                WORD_W = 16,
  parameter int                LFSR_W = 5,
  parameter int                FB_TAP = 2,
  parameter logic [WORD_W-1:0] SEED   = 16'h1A47,
  parameter logic [LFSR_W-2:0] TAIL   = 4'b0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int STATE_W = WORD_W * LFSR_W;

  logic [STATE_W-1:0] state_all;

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    logic [LFSR_W-1:0] st_q;
    logic              fb;

    assign fb = st_q[LFSR_W-1] ^ st_q[FB_TAP];

    always_ff @(posedge clk) begin
      if (rst)          st_q <= {SEED[i], TAIL};
      else if (step_en) st_q <= {st_q[LFSR_W-2:0], fb};
    end

    assign word_o[i]                      = st_q[LFSR_W-1];
    assign state_all[i*LFSR_W +: LFSR_W] = st_q;
  end

  assign word_vld_o = step_en & ~rst;
endmodule

// File: rtl/bitslice_prbs_gen_chk.sv
module bitslice_prbs_gen_chk #(
  parameter int                WORD_W = 16,
  parameter int                LFSR_W = 5,
  parameter logic [WORD_W-1:0] SEED   = 16'h1A47
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     step_en,
  input logic [WORD_W-1:0]        word_o,
  input logic                     word_vld_o,
  input logic [WORD_W*LFSR_W-1:0] state_all
);
  localparam int PERIOD = (1 << LFSR_W) - 1;

  logic [WORD_W-1:0] next_msb;
  logic [LFSR_W-1:0] phase_q;

  for (genvar i = 0; i < WORD_W; i++) begin : g_chk
    assign next_msb[i] = state_all[i*LFSR_W + LFSR_W - 2];

    AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state_all[i*LFSR_W +: LFSR_W] != '0);  // R2
  end

  always_ff @(posedge clk) begin
    if (rst)                                       phase_q <= '0;
    else if (step_en && phase_q == LFSR_W'(PERIOD - 1)) phase_q <= '0;
    else if (step_en)                              phase_q <= phase_q + 1'b1;
  end

  AST_RESET_SEED: assert property (@(posedge clk)
    rst |=> word_o == SEED);  // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(word_o));  // R4

  AST_VLD_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_en |-> !word_vld_o);  // R5

  AST_ONE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    step_en |=> word_o == $past(next_msb));  // R3

  AST_PERIOD_MARK: assert property (@(posedge clk) disable iff (rst)
    phase_q == '0 |-> word_o == SEED);  // R6
endmodule

bind bitslice_prbs_gen bitslice_prbs_gen_chk #(
  .WORD_W(WORD_W), .LFSR_W(LFSR_W), .SEED(SEED)
) chk_i (
  .clk(clk), .rst(rst), .step_en(step_en), .word_o(word_o),
  .word_vld_o(word_vld_o), .state_all(state_all)
);

// File: tb/bitslice_prbs_gen_tb.sv
`timescale 1ns/1ps
module bitslice_prbs_gen_tb_top;
  localparam logic [15:0] SEED = 16'h1A47;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o;

  int total = 0;
  int bad = 0;
  int steps = 0;
  bit done = 0;
  logic [15:0] seen, prev_seen;
  bit tab0 [31];
  bit tab1 [31];
  logic [15:0] rec [93];

  always #2.5 clk = ~clk;

  bitslice_prbs_gen dut_i (
    .clk(clk), .rst(rst), .step_en(step_en),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void build_tabs();
    bit b0 [31];
    bit b1 [31];
    b0[0] = 0; b1[0] = 1;
    for (int j = 1; j < 4; j++) begin b0[j] = 0; b1[j] = 0; end
    b0[4] = 1; b1[4] = 1;
    for (int j = 0; j + 5 < 31; j++) begin
      b0[j+5] = b0[j+2] ^ b0[j];
      b1[j+5] = b1[j+2] ^ b1[j];
    end
    tab0 = b0; tab1 = b1;
  endfunction

  function automatic logic [15:0] model(input int n);
    logic [15:0] w;
    int k = n % 31;
    for (int i = 0; i < 16; i++) w[i] = SEED[i] ? tab1[k] : tab0[k];
    return w;
  endfunction

  task automatic cyc(input logic r, input logic e);
    @(negedge clk);
    rst = r; step_en = e;
    #1;
    prev_seen = seen;
    seen = word_o;
    chk(word_vld_o == (e && !r), "R5 valid", {15'd0, word_vld_o}, {15'd0, e && !r});
    if (!r) begin
      chk(word_o == model(steps), "R2/R3 word", word_o, model(steps));
      if (steps % 31 == 0) chk(word_o == SEED, "R6 marker", word_o, SEED);
    end
    @(posedge clk);
    if (r) steps = 0;
    else if (e) steps++;
  endtask

  initial begin
    build_tabs();
    void'($urandom(32'd4242));
    seen = '0;
    cyc(1, 1);
    cyc(1, 0);
    cyc(0, 0);
    chk(seen == SEED, "R1 reset word", seen, SEED);
    chk(word_vld_o == 1'b0, "R4 valid low idle", {15'd0, word_vld_o}, 16'd0);

    for (int k = 0; k < 93; k++) begin
      cyc(0, 1);
      rec[k] = seen;
    end
    for (int k = 0; k < 62; k++)
      chk(rec[k+31] == rec[k], "R6 repeat", rec[k+31], rec[k]);
    chk(rec[62] == SEED, "R6 third period start", rec[62], SEED);
    for (int p = 1; p < 31; p++) begin
      bit differs = 0;
      for (int k = 0; k < 62; k++) if (rec[k] != rec[k+p]) differs = 1;
      chk(differs, "R7 no short period", 16'(p), 16'd31);
    end

    cyc(0, 1);
    cyc(1, 1);
    cyc(0, 0);
    chk(seen == SEED, "R8 reset over enable", seen, SEED);

    for (int c = 0; c < 3000; c++) begin
      logic e = ($urandom % 4) != 0;
      logic r = ($urandom % 150) == 0;
      cyc(r, e);
      if (!r && !e) begin
        cyc(0, 0);
        chk(seen == prev_seen, "R4 hold", seen, prev_seen);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule